// File: doc/BRIEF.md
# Sigma-Delta Converter Calibration and Correction Engine

This block sits behind the decimation filter of an oversampled converter. It applies offset and gain correction to each raw 24-bit result and sends the corrected value out with an active-low data-ready strobe. It can also run the calibration steps that fill its correction registers. A 3-bit mode input chooses the operation. Normal conversion corrects each sample. The zero-scale step captures the offset. The positive and negative full-scale steps each derive one of two gain slopes. Values on the positive side of zero are scaled by the positive slope, and values below zero by the negative slope.

The offset step must come first. A full-scale step requested before it is refused and sets a sticky error flag. The two full-scale steps may then run in either order. A full-scale step computes its slope with a sequential divider. While the divider runs, incoming samples are dropped. The host can also load any of the three registers directly. Loading an offset of zero and both slopes at 800000h gives an uncorrected pass-through.

Top module: `sdcal_engine`

## Requirements
- R1: After synchronous reset, `res_data` is 0, `drdy_n` is 1, `seq_err` is 0, the offset register is 0 and both slopes are 800000h (unity), so a normal sample passes unchanged.
- R2: Mode codes are 000 normal, 001 zero-scale step, 010 positive full-scale step and 011 negative full-scale step. A sample taken under codes 100 to 111 changes neither the output, `drdy_n`, the registers nor the error flag.
- R3: In normal mode an accepted sample produces, one clock later, res = floor((raw − offset) × slope / 2^23), saturated to [−800000h, 7FFFFFh]. The positive slope is used when raw − offset ≥ 0 and the negative slope otherwise. `drdy_n` goes low in the same cycle.
- R4: A zero-scale sample is stored as the offset one clock later. The output becomes 0 with `drdy_n` low, and the full-scale steps are enabled from then on.
- R5: A full-scale sample taken before any zero-scale step has completed sets `seq_err` one clock later and changes no register, no output and not `drdy_n`.
- R6: A full-scale step uses d = raw − offset (positive step) or offset − raw (negative step). It stores slope = floor(2^46 / d) in the matching register, or FFFFFFh when d ≤ 400000h. Exactly 25 clocks after the accepting edge it outputs the corrected value of the captured sample using the new slope, with `drdy_n` low.
- R7: Once the zero-scale step has completed, the positive and negative full-scale steps are each accepted in either order. Each step updates only its own slope.
- R8: From the clock after a full-scale sample is accepted until its result is output, incoming samples of every mode are ignored.
- R9: `host_we` with `host_sel` 0 writes the offset, 1 the positive slope and 2 the negative slope. Code 3 writes nothing. A write takes effect for samples accepted on later clocks. A calibration write in the same cycle takes precedence.
- R10: `drdy_n` returns high one clock after `drdy_ack` or after a full-scale sample is accepted, unless a new result lands in that same cycle. A new result keeps it low.
- R11: `seq_err` remains set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operation select (see R2) |
| smp_valid | input | 1 | Raw sample present this cycle |
| smp_data | input | 24 | Raw two's-complement sample |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select (see R9) |
| host_data | input | 24 | Host write value |
| drdy_ack | input | 1 | Host has taken the current result |
| res_data | output | 24 | Corrected two's-complement result |
| drdy_n | output | 1 | Active-low result-ready flag |
| seq_err | output | 1 | Sticky calibration-order error |

## Verification
The hardest state to reach is the completion of a full-scale step. There, the new slope must be stored and also applied to the captured sample in the same cycle, while later samples have been dropped throughout the 25-clock divide. The stimulus gets there by running a zero-scale step at a non-zero offset. It then runs the negative step before the positive one, injecting samples during each divide. A further step with a tiny span forces the slope clamp. A long random phase mixes modes, acknowledges and host writes, so calibrations overlap with register writes and reserved codes.

// File: rtl/sdcal_pkg.sv
package sdcal_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_ZERO   = 3'd1,
        MD_POSFS  = 3'd2,
        MD_NEGFS  = 3'd3
    } mode_e;

    typedef enum logic [1:0] {
        SEL_OFS  = 2'd0,
        SEL_POS  = 2'd1,
        SEL_NEG  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    // calibration write request towards the register file
    typedef struct packed {
        logic ofs_we;
        logic slope_we;
        logic to_pos;
    } calwr_t;

    function automatic logic is_gain_mode(input logic [2:0] m);
        return (m == MD_POSFS) || (m == MD_NEGFS);
    endfunction

endpackage

// File: rtl/sdcal_corr.sv
module sdcal_corr #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] raw,
    input  logic signed [W-1:0] ofs,
    input  logic        [W-1:0] slope_pos,
    input  logic        [W-1:0] slope_neg,
    output logic signed [W-1:0] res
);
    localparam int PW = 2 * W + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic signed [W:0]    diff;
    logic        [W-1:0]  sl;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        diff    = {raw[W-1], raw} - {ofs[W-1], ofs};
        sl      = diff[W] ? slope_neg : slope_pos;
        prod    = PW'(diff) * PW'($signed({1'b0, sl}));
        shifted = prod >>> (W - 1);
        if (shifted > MAXV)
            res = MAXV[W-1:0];
        else if (shifted < MINV)
            res = MINV[W-1:0];
        else
            res = shifted[W-1:0];
    end
endmodule

// File: rtl/sdcal_div.sv
module sdcal_div #(
    parameter int W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic signed [W:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    quot
);
    localparam int CW = $clog2(W + 1);
    localparam logic signed [W:0] LIMIT = {2'b00, 1'b1, {(W-2){1'b0}}};
    localparam logic [2*W:0] DIVIDEND = {3'b001, {(2*W-2){1'b0}}};

    logic [W-1:0]  dvs;
    logic [W-1:0]  q;
    logic [W-1:0]  rem;
    logic [CW-1:0] cnt;
    logic          clamp;
    logic [W:0]    rem_sh;
    logic [W:0]    sub;

    assign rem_sh = {rem, 1'b0};
    assign sub    = rem_sh - {1'b0, dvs};
    assign quot   = clamp ? {W{1'b1}} : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            q     <= '0;
            dvs   <= '0;
            clamp <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                cnt   <= CW'(W);
                clamp <= (divisor <= LIMIT);
                dvs   <= divisor[W-1:0];
                rem   <= LIMIT[W-1:0];
                q     <= '0;
            end else if (busy) begin
                rem <= sub[W] ? rem_sh[W-1:0] : sub[W-1:0];
                q   <= {q[W-2:0], ~sub[W]};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    logic [2*W:0] chk_lo;
    logic [2*W:0] chk_hi;
    assign chk_lo = (2*W+1)'(q) * (2*W+1)'(dvs);
    assign chk_hi = chk_lo + (2*W+1)'(dvs);

    AST_DIV_QUOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done && !clamp) |-> (chk_lo <= DIVIDEND && chk_hi > DIVIDEND)); // R6
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != CW'(1)) |=> busy); // R8
endmodule

// File: rtl/sdcal_regfile.sv
module sdcal_regfile
    import sdcal_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_we,
    input  logic [1:0]   host_sel,
    input  logic [W-1:0] host_data,
    input  calwr_t       cal_wr,
    input  logic [W-1:0] cal_data,
    output logic [W-1:0] ofs,
    output logic [W-1:0] slope_pos,
    output logic [W-1:0] slope_neg
);
    localparam logic [W-1:0] UNITY = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs       <= '0;
            slope_pos <= UNITY;
            slope_neg <= UNITY;
        end else begin
            if (cal_wr.ofs_we)
                ofs <= cal_data;
            else if (host_we && host_sel == SEL_OFS)
                ofs <= host_data;

            if (cal_wr.slope_we && cal_wr.to_pos)
                slope_pos <= cal_data;
            else if (host_we && host_sel == SEL_POS)
                slope_pos <= host_data;

            if (cal_wr.slope_we && !cal_wr.to_pos)
                slope_neg <= cal_data;
            else if (host_we && host_sel == SEL_NEG)
                slope_neg <= host_data;
        end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!host_we && !cal_wr.ofs_we && !cal_wr.slope_we) |=>
        ($stable(ofs) && $stable(slope_pos) && $stable(slope_neg))); // R9
    AST_SEL3_INERT: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel == SEL_NONE && !cal_wr.ofs_we && !cal_wr.slope_we) |=>
        ($stable(ofs) && $stable(slope_pos) && $stable(slope_neg))); // R9
endmodule

// File: rtl/sdcal_engine.sv
module sdcal_engine
    import sdcal_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   mode,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         host_we,
    input  logic [1:0]   host_sel,
    input  logic [W-1:0] host_data,
    input  logic         drdy_ack,
    output logic [W-1:0] res_data,
    output logic         drdy_n,
    output logic         seq_err
);
    logic [W-1:0] ofs_q, spos_q, sneg_q;
    logic         div_busy, div_done;
    logic [W-1:0] quot;
    logic         zs_done;
    logic         tgt_pos;
    logic [W-1:0] cap_raw;

    logic eng_busy, take, acc_norm, acc_zero, req_gain, acc_gain, bad_gain;
    logic signed [W:0] dpos, divisor;
    calwr_t       cal_wr;
    logic [W-1:0] cal_data;
    logic [W-1:0] c_raw, c_pos, c_neg, c_res;

    assign eng_busy = div_busy | div_done;
    assign take     = smp_valid && !eng_busy;
    assign acc_norm = take && (mode == MD_NORMAL);
    assign acc_zero = take && (mode == MD_ZERO);
    assign req_gain = take && is_gain_mode(mode);
    assign acc_gain = req_gain && zs_done;
    assign bad_gain = req_gain && !zs_done;

    assign dpos    = {smp_data[W-1], smp_data} - {ofs_q[W-1], ofs_q};
    assign divisor = (mode == MD_POSFS) ? dpos : -dpos;

    always_comb begin
        cal_wr.ofs_we   = acc_zero;
        cal_wr.slope_we = div_done;
        cal_wr.to_pos   = tgt_pos;
        cal_data        = acc_zero ? smp_data : quot;
        c_raw           = div_done ? cap_raw : smp_data;
        c_pos           = (div_done && tgt_pos)  ? quot : spos_q;
        c_neg           = (div_done && !tgt_pos) ? quot : sneg_q;
    end

    sdcal_regfile #(.W(W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_data (host_data),
        .cal_wr    (cal_wr),
        .cal_data  (cal_data),
        .ofs       (ofs_q),
        .slope_pos (spos_q),
        .slope_neg (sneg_q)
    );

    sdcal_div #(.W(W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .start   (acc_gain),
        .divisor (divisor),
        .busy    (div_busy),
        .done    (div_done),
        .quot    (quot)
    );

    sdcal_corr #(.W(W)) corr_i (
        .raw       (c_raw),
        .ofs       (ofs_q),
        .slope_pos (c_pos),
        .slope_neg (c_neg),
        .res       (c_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data <= '0;
            drdy_n   <= 1'b1;
            seq_err  <= 1'b0;
            zs_done  <= 1'b0;
            tgt_pos  <= 1'b0;
            cap_raw  <= '0;
        end else begin
            if (bad_gain)
                seq_err <= 1'b1;
            if (acc_zero)
                zs_done <= 1'b1;
            if (acc_gain) begin
                tgt_pos <= (mode == MD_POSFS);
                cap_raw <= smp_data;
            end
            if (acc_norm || div_done) begin
                res_data <= c_res;
                drdy_n   <= 1'b0;
            end else if (acc_zero) begin
                res_data <= '0;
                drdy_n   <= 1'b0;
            end else if (acc_gain || drdy_ack) begin
                drdy_n <= 1'b1;
            end
        end
    end

    AST_NORM_DRDY: assert property (@(posedge clk) disable iff (rst)
        acc_norm |=> !drdy_n); // R3
    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        acc_zero |=> (res_data == '0 && !drdy_n)); // R4
    AST_EARLY_GAIN_ERR: assert property (@(posedge clk) disable iff (rst)
        bad_gain |=> seq_err); // R5
    AST_EARLY_GAIN_REGS: assert property (@(posedge clk) disable iff (rst)
        (bad_gain && !host_we) |=> ($stable(ofs_q) && $stable(spos_q) && $stable(sneg_q))); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err); // R11
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (take && mode[2] && !drdy_ack) |=> ($stable(res_data) && $stable(drdy_n))); // R2
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && div_busy) |=> $stable(res_data)); // R8
    AST_ACK_RAISE: assert property (@(posedge clk) disable iff (rst)
        (drdy_ack && !acc_norm && !acc_zero && !div_done) |=> drdy_n); // R10
endmodule

// File: tb/sdcal_engine_tb.sv
module sdcal_engine_tb_top;
    localparam int W = 24;
    localparam longint UNI = 64'h800000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   mode = 3'd0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         host_we = 1'b0;
    logic [1:0]   host_sel = 2'd0;
    logic [W-1:0] host_data = '0;
    logic         drdy_ack = 1'b0;
    logic [W-1:0] res_data;
    logic         drdy_n;
    logic         seq_err;

    always #2 clk = ~clk;

    sdcal_engine #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .mode(mode), .smp_valid(smp_valid),
        .smp_data(smp_data), .host_we(host_we), .host_sel(host_sel),
        .host_data(host_data), .drdy_ack(drdy_ack), .res_data(res_data),
        .drdy_n(drdy_n), .seq_err(seq_err)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    started = 0;
    string phase = "R1";

    // behavioural reference state
    longint m_ofs, m_sp, m_sn, m_out, m_cap, m_pend, m_d;
    int     m_cnt;
    bit     m_zs, m_err, m_rdy, m_tpos;
    longint x_ofs, x_sp, x_sn, x_out, x_raw;
    int     x_cnt;
    bit     x_rdy, x_done, x_take;

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint corr(input longint raw, input longint ofs,
                                    input longint sp, input longint sn);
        longint diff, p, r;
        diff = raw - ofs;
        p = diff * ((diff < 0) ? sn : sp);
        r = p >>> 23;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r;
    endfunction

    function automatic longint slope_of(input longint d);
        if (d <= 64'sd4194304) return 64'hFFFFFF;
        return (64'sd1 <<< 46) / d;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        started <= 1'b1;
        if (rst) begin
            m_ofs = 0; m_sp = UNI; m_sn = UNI; m_out = 0; m_cap = 0; m_pend = 0;
            m_cnt = 0; m_zs = 0; m_err = 0; m_rdy = 1; m_tpos = 0;
        end else begin
            x_ofs = m_ofs; x_sp = m_sp; x_sn = m_sn; x_out = m_out;
            x_rdy = m_rdy; x_cnt = m_cnt; x_done = 0;
            x_take = smp_valid && (m_cnt == 0);
            x_raw = sx(smp_data);
            if (m_cnt > 0) begin
                x_cnt = m_cnt - 1;
                if (x_cnt == 0) x_done = 1;
            end
            if (host_we) begin
                case (host_sel)
                    2'd0: x_ofs = sx(host_data);
                    2'd1: x_sp = longint'(host_data);
                    2'd2: x_sn = longint'(host_data);
                    default: ;
                endcase
            end
            if (x_done) begin
                if (m_tpos) x_sp = m_pend; else x_sn = m_pend;
                x_out = corr(m_cap, m_ofs, m_tpos ? m_pend : m_sp, m_tpos ? m_sn : m_pend);
                x_rdy = 0;
            end else if (x_take && mode == 3'd0) begin
                x_out = corr(x_raw, m_ofs, m_sp, m_sn);
                x_rdy = 0;
            end else if (x_take && mode == 3'd1) begin
                x_ofs = x_raw; m_zs = 1; x_out = 0; x_rdy = 0;
            end else if (x_take && (mode == 3'd2 || mode == 3'd3)) begin
                if (!m_zs) begin
                    m_err = 1;
                    if (drdy_ack) x_rdy = 1;
                end else begin
                    m_d = (mode == 3'd2) ? (x_raw - m_ofs) : (m_ofs - x_raw);
                    m_pend = slope_of(m_d);
                    m_tpos = (mode == 3'd2);
                    m_cap = x_raw;
                    x_cnt = 25;
                    x_rdy = 1;
                end
            end else if (drdy_ack) begin
                x_rdy = 1;
            end
            m_ofs = x_ofs; m_sp = x_sp; m_sn = x_sn; m_out = x_out;
            m_rdy = x_rdy; m_cnt = x_cnt;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk({phase, " res_data"}, sx(res_data), m_out);
            chk({phase, " drdy_n"}, longint'(drdy_n), longint'(m_rdy));
            chk({phase, " seq_err"}, longint'(seq_err), longint'(m_err));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic smp(input logic [2:0] m, input longint d);
        @(negedge clk);
        mode = m; smp_data = W'(d); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic hwr(input logic [1:0] s, input longint d);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_data = W'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        drdy_ack = 1'b1;
        @(negedge clk);
        drdy_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= 100000) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=<%0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        phase = "R1";
        chk("R1 reset res_data", sx(res_data), 0);
        chk("R1 reset drdy_n", longint'(drdy_n), 1);
        chk("R1 reset seq_err", longint'(seq_err), 0);
        smp(3'd0, 12345);
        chk("R1 unity pass-through", sx(res_data), 12345);

        phase = "R3";
        smp(3'd0, -100);
        smp(3'd0, 8388607);
        smp(3'd0, -8388608);
        phase = "R10";
        ack();
        chk("R10 ack raises drdy_n", longint'(drdy_n), 1);
        smp(3'd0, 77);
        smp(3'd0, 78);

        phase = "R2";
        ack();
        for (int m = 4; m < 8; m++) smp(3'(m), 1000 * m);
        chk("R2 reserved keeps drdy_n", longint'(drdy_n), 1);

        phase = "R5";
        smp(3'd2, 5000000);
        smp(3'd3, -5000000);
        chk("R5 early gain flags error", longint'(seq_err), 1);

        phase = "R4";
        smp(3'd1, 1000);
        chk("R4 zero-scale output", sx(res_data), 0);
        smp(3'd0, 1500);

        phase = "R7";
        smp(3'd3, 1000 - 6000000);
        phase = "R8";
        smp(3'd0, 400);
        smp(3'd1, 50);
        idle(26);
        phase = "R6";
        chk("R6 negative step result", sx(res_data), -8388608);
        phase = "R7";
        smp(3'd2, 1000 + 7000000);
        phase = "R8";
        smp(3'd3, 3);
        idle(26);
        phase = "R3";
        smp(3'd0, 1000 + 3500000);
        smp(3'd0, 1000 - 3500000);
        smp(3'd0, 8388607);
        smp(3'd0, -8388608);

        phase = "R6";
        smp(3'd2, 2000);
        idle(27);
        smp(3'd0, 1100);
        chk("R6 clamped slope", sx(res_data), (100 * 64'hFFFFFF) >>> 23);

        phase = "R9";
        hwr(2'd3, 123);
        hwr(2'd0, 0);
        hwr(2'd1, UNI);
        hwr(2'd2, UNI);
        smp(3'd0, -4242);
        chk("R9 host unity restore", sx(res_data), -4242);
        hwr(2'd1, 64'h400000);
        smp(3'd0, 4000);
        chk("R9 host half slope", sx(res_data), 2000);

        phase = "R10";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            mode      = 3'($urandom_range(0, 7));
            smp_data  = W'($urandom);
            smp_valid = ($urandom_range(0, 2) != 0);
            drdy_ack  = ($urandom_range(0, 3) == 0);
            host_we   = ($urandom_range(0, 9) == 0);
            host_sel  = 2'($urandom_range(0, 3));
            host_data = W'($urandom);
        end
        @(negedge clk);
        smp_valid = 1'b0; drdy_ack = 1'b0; host_we = 1'b0;
        idle(30);

        phase = "R11";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk("R11 reset clears error", longint'(seq_err), 0);
        idle(2);
        finish_run();
    end
endmodule